// File: doc/BRIEF.md
# Tree-Structured Carry-Lookahead Adder

This block adds two unsigned W-bit operands and a carry-in, giving a W-bit sum and a carry-out. It is purely combinational. W must be a power of two; the default is 8. There is no behavioural `+` in the design. It uses two kinds of cell.

- **Bit cells** form a generate term and a propagate term for each bit position. Each one also forms its sum bit from the carry that reaches that position.
- **Group cells** are arranged as a binary tree. Each merges the terms of its two child groups on the way up. On the way down it hands carries back toward the bits. The left child of every group cell covers the more significant half of the bits.

The carry into any bit is built from the carry-in and group terms only, so no position waits for its neighbour to settle. The longest path crosses two bit-cell levels and 2·log2(W) − 1 group-cell levels. The block fits anywhere a single-cycle adder with a short carry path is wanted, such as the final adder of a multiplier or an accumulator.

Top module: `cla_tree`

## Requirements
- R1: With both operands zero, the sum equals the carry-in zero-extended to W bits, and the carry-out is 0.
- R2: For every pair of operands and both values of carry-in, {cout, sum} equals a + b + cin as an unsigned (W+1)-bit value.
- R3: When every bit position propagates (a XOR b all ones, a AND b zero), the carry-in passes through the whole tree. With cin = 0 the result is sum all ones and cout = 0. With cin = 1 it is sum all zeros and cout = 1.
- R4: A carry generated at bit 0 and propagated by every higher bit reaches the carry-out. For example, with a = 1 and b = all ones, the result is sum = cin and cout = 1.
- R5: With both operands all ones, cout is 1 and the sum is all ones except bit 0, which equals cin.
- R6: The result does not depend on operand order: swapping a and b leaves sum and cout unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that must cross every level of the tree. This happens when the carry-in or a bit-0 generate has to pass through every group cell, both up and back down. It occurs only when every position propagates, which is a small fraction of random operand pairs. The stimulus places these full-length chains deliberately, with an all-propagate operand split and with a single low generate under all-propagate bits. It then sweeps every operand pair with both carry-in values, so that each group cell sees each combination of child terms and incoming carry.

// File: rtl/cla_tree.sv
module cla_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  // Heap numbering: node 1 is the root, nodes W..2W-1 are bit cells.
  // Node k has left child 2k (more significant) and right child 2k+1.
  localparam int NN = 2 * W;

  logic [NN-1:1] grp_g;
  logic [NN-1:1] grp_p;
  logic [NN-1:1] grp_c;

  assign grp_c[1] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int LF = NN - 1 - i;
    assign grp_g[LF] = a[i] & b[i];
    assign grp_p[LF] = a[i] ^ b[i];
    assign sum[i]    = grp_p[LF] ^ grp_c[LF];
  end

  for (genvar k = 1; k < W; k++) begin : g_grp
    assign grp_g[k]       = grp_g[2*k] | (grp_p[2*k] & grp_g[2*k+1]);
    assign grp_p[k]       = grp_p[2*k] & grp_p[2*k+1];
    assign grp_c[2*k+1]   = grp_c[k];
    assign grp_c[2*k]     = grp_g[2*k+1] | (grp_p[2*k+1] & grp_c[k]);
  end

  assign cout = grp_g[1] | (grp_p[1] & cin);
endmodule

module cla_tree_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout
);
  logic [W:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    if (!$isunknown({a, b, cin, sum, cout})) begin
      p_total_r2: assert ({cout, sum} == ref_total)
        else $error("R2 total mismatch");
      p_zero_r1: assert (!(a == '0 && b == '0) || (cout == 1'b0 && sum == {{(W-1){1'b0}}, cin}))
        else $error("R1 zero operands");
      p_chain_r3: assert (!((a ^ b) == '1 && (a & b) == '0) || (cout == cin && sum == {W{~cin}}))
        else $error("R3 propagate chain");
      p_ones_r5: assert (!(a == '1 && b == '1) || (cout && sum[W-1:1] == '1 && sum[0] == cin))
        else $error("R5 all ones");
    end
  end
endmodule

bind cla_tree cla_tree_chk #(.W(W)) u_chk (.*);

// File: tb/test_cla_tree.sv
module test_cla_tree;
  localparam int W = 8;

  typedef struct {
    logic [W:0] exp;
    string      req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  item_t sb[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #2.5 clk = ~clk;

  cla_tree #(.W(W)) i_cla_tree (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input logic [W:0] ex, input string rq);
    item_t it;
    @(posedge clk);
    a   <= va;
    b   <= vb;
    cin <= vc;
    it.exp = ex;
    it.req = rq;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_run++;
      if ({cout, sum} !== it.exp) begin
        n_fail++;
        $display("FAIL %s a=%0h b=%0h cin=%0b got=%0h exp=%0h",
                 it.req, a, b, cin, {cout, sum}, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // R1: zero operands
    drive('0, '0, 1'b0, '0, "R1");
    drive('0, '0, 1'b1, {{W{1'b0}}, 1'b1}, "R1");
    // R3: every position propagates
    drive(8'hA5, 8'h5A, 1'b0, {1'b0, {W{1'b1}}}, "R3");
    drive(8'hA5, 8'h5A, 1'b1, {1'b1, {W{1'b0}}}, "R3");
    drive(8'hF0, 8'h0F, 1'b1, {1'b1, {W{1'b0}}}, "R3");
    // R4: generate at bit 0, propagate above
    drive(8'h01, 8'hFF, 1'b0, {1'b1, {W{1'b0}}}, "R4");
    drive(8'h01, 8'hFF, 1'b1, {1'b1, {(W-1){1'b0}}, 1'b1}, "R4");
    // R5: both all ones
    drive('1, '1, 1'b0, {1'b1, {(W-1){1'b1}}, 1'b0}, "R5");
    drive('1, '1, 1'b1, {1'b1, {W{1'b1}}}, "R5");
    // R6: operand order
    drive(8'h37, 8'hC9, 1'b1, 9'h101, "R6");
    drive(8'hC9, 8'h37, 1'b1, 9'h101, "R6");
    drive(8'h80, 8'h81, 1'b0, 9'h101, "R6");
    drive(8'h81, 8'h80, 1'b0, 9'h101, "R6");
    // R2: exhaustive sweep
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          drive(W'(x), W'(y), c[0], (W+1)'(x + y + c), "R2");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule